// File: doc/BRIEF.md
# Interlaced Field Timing Generator

This block produces the raster timing for interlaced video. It counts pixel positions on a pixel clock enable and walks through odd and even fields. In each field it places the active lines, the dark calibration lines and the blanking. Its outputs are a frame-valid strobe, a line-valid strobe, a field parity flag, the column and row counters, and a per-position class code. It also gates a pixel data word to zero wherever the position is blanking.

Two standards are supported. The standard is chosen by a mode input that is sampled only while reset is held. In NTSC mode the three dark lines follow the 240 image lines. In PAL mode 24 dark lines come before the image lines and 24 come after them. Active lines carry 720 pixel positions in both standards. A pedestal request is also captured at reset. It is passed on only in NTSC mode.

The vertical sequencer is a state machine with these states:
- `V_IDLE`: after reset, waiting for the first enable.
- `V_TOP_DARK`: the dark lines at the top of the field.
- `V_IMAGE`: the image lines.
- `V_BOT_DARK`: the dark lines at the bottom of the field.
- `V_BLANK`: vertical blanking.

It moves through them as follows:
- From `V_IDLE` it goes to `V_TOP_DARK` on the first enable. In NTSC mode, which has no top dark rows, it goes to `V_IMAGE` instead.
- At the line end that completes the last row of a region, it goes to the next region.
- When `V_BOT_DARK` is empty, `V_IMAGE` goes straight to `V_BLANK`.
- From `V_BLANK` it returns to the first active region at the end of the field.

The horizontal sequencer has two states:
- `H_ACTIVE` goes to `H_BLANK` after the last active column.
- `H_BLANK` goes back to `H_ACTIVE` at the line end.

Top module: `field_timing_gen`

## Requirements
- R1: While reset is held, and until the first `pix_en` after reset, the outputs are as follows: `col_cnt` = 0, `row_cnt` = 0, `field_even` = 0 (odd field), `frame_valid` = 0, `line_valid` = 0, `pix_sel` = 0 and `pix_out` = 0. The first enable does not advance the counters; it makes position (0,0) live.
- R2: Each enable after the first advances `col_cnt` by one. After the last column of the line (line total − 1, with the line total set per standard), `col_cnt` wraps to 0 and `row_cnt` advances. Without an enable, the counters and the parity are unchanged. Columns 0 to ACT_PIX−1 are active and the rest of the line is horizontal blanking.
- R3: In NTSC mode, rows 0 to IMG_LINES−1 are image rows (`pix_sel` = 1). The next NTSC_DARK rows are dark rows (`pix_sel` = 2). The remaining rows of the field are vertical blanking.
- R4: In PAL mode, the first PAL_DARK rows are dark. They are followed by IMG_LINES image rows and then PAL_DARK more dark rows. The remaining rows of the field are vertical blanking.
- R5: `frame_valid` is 1 for every position of an image or dark row, and 0 throughout vertical blanking. `line_valid` is 1 only where `frame_valid` is 1 and the column is active.
- R6: `field_even` toggles at column 0 of the first vertical blanking row of each field. The field period that starts with `field_even` = 0 has the odd line count for the standard. The next one has the even line count, and the two alternate.
- R7: The `mode_pal` and `pedestal_req` inputs are sampled only while `rst_n` is low. Changes to them after reset has been released have no effect on timing or on `pedestal_on`.
- R8: `pedestal_on` = the sampled request AND NOT the sampled PAL mode.
- R9: `pix_sel` encodes 0 for blanking, 1 for image and 2 for dark. `pix_out` is 0 at blanking positions. At image and dark positions it equals `pix_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode and pedestal inputs are sampled while it is low |
| pix_en | input | 1 | Pixel clock enable; one pixel position per enable |
| mode_pal | input | 1 | 0 selects NTSC, 1 selects PAL (sampled at reset) |
| pedestal_req | input | 1 | Pedestal request (sampled at reset) |
| pix_data | input | DATA_W | Pixel word to be gated |
| frame_valid | output | 1 | High during the active rows of a field |
| line_valid | output | 1 | High at active pixel positions |
| field_even | output | 1 | Field parity, 0 = odd |
| col_cnt | output | COL_W | Column position in the line |
| row_cnt | output | ROW_W | Row position in the field period |
| pix_sel | output | 2 | Position class: 0 blank, 1 image, 2 dark |
| pix_out | output | DATA_W | `pix_data`, or zero at blanking positions |
| pedestal_on | output | 1 | Pedestal enable, forced off in PAL mode |

## Verification
Several events can fall in the same enable tick:
- A line end that also leaves the last active row, which changes the vertical state and toggles the field parity together.
- A line end that also closes the field, which resets the row counter and returns to the first active region.
- Gaps in the enable that arrive exactly at these boundaries.

The bench provokes all of them. It sweeps every position of two full frames in each standard, with the enable running continuously in some runs and with one tick in four withheld in others. It toggles the mode and pedestal inputs after reset has been released. The position, class, parity and gating expected at each tick are computed from the tick count alone.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
    typedef enum logic [1:0] {
        SEL_BLANK = 2'd0,
        SEL_IMAGE = 2'd1,
        SEL_DARK  = 2'd2
    } pix_sel_e;

    typedef enum logic [2:0] {
        V_IDLE,
        V_TOP_DARK,
        V_IMAGE,
        V_BOT_DARK,
        V_BLANK
    } vstate_e;

    typedef enum logic {
        H_ACTIVE,
        H_BLANK
    } hstate_e;
endpackage

// File: rtl/ftg_cfg_latch.sv
module ftg_cfg_latch #(
    parameter int COL_W           = 10,
    parameter int ROW_W           = 9,
    parameter int IMG_LINES       = 240,
    parameter int NTSC_DARK       = 3,
    parameter int PAL_DARK        = 24,
    parameter int NTSC_LINE_TOTAL = 858,
    parameter int PAL_LINE_TOTAL  = 864,
    parameter int NTSC_ODD_LINES  = 263,
    parameter int NTSC_EVEN_LINES = 262,
    parameter int PAL_ODD_LINES   = 313,
    parameter int PAL_EVEN_LINES  = 312
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_pal,
    input  logic             pedestal_req,
    output logic [COL_W-1:0] line_last,
    output logic [ROW_W-1:0] top_rows,
    output logic [ROW_W-1:0] bot_row,
    output logic [ROW_W-1:0] blank_row,
    output logic [ROW_W-1:0] odd_last,
    output logic [ROW_W-1:0] even_last,
    output logic             pedestal_on
);
    localparam logic [COL_W-1:0] N_LINE_LAST  = COL_W'(NTSC_LINE_TOTAL - 1);
    localparam logic [COL_W-1:0] P_LINE_LAST  = COL_W'(PAL_LINE_TOTAL - 1);
    localparam logic [ROW_W-1:0] N_BOT_ROW    = ROW_W'(IMG_LINES);
    localparam logic [ROW_W-1:0] N_BLANK_ROW  = ROW_W'(IMG_LINES + NTSC_DARK);
    localparam logic [ROW_W-1:0] P_TOP_ROWS   = ROW_W'(PAL_DARK);
    localparam logic [ROW_W-1:0] P_BOT_ROW    = ROW_W'(PAL_DARK + IMG_LINES);
    localparam logic [ROW_W-1:0] P_BLANK_ROW  = ROW_W'(2 * PAL_DARK + IMG_LINES);
    localparam logic [ROW_W-1:0] N_ODD_LAST   = ROW_W'(NTSC_ODD_LINES - 1);
    localparam logic [ROW_W-1:0] N_EVEN_LAST  = ROW_W'(NTSC_EVEN_LINES - 1);
    localparam logic [ROW_W-1:0] P_ODD_LAST   = ROW_W'(PAL_ODD_LINES - 1);
    localparam logic [ROW_W-1:0] P_EVEN_LAST  = ROW_W'(PAL_EVEN_LINES - 1);

    logic pal_q;
    logic ped_q;

    // capture strap inputs only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_q <= mode_pal;
            ped_q <= pedestal_req;
        end
    end

    always_comb begin
        if (pal_q) begin
            line_last = P_LINE_LAST;
            top_rows  = P_TOP_ROWS;
            bot_row   = P_BOT_ROW;
            blank_row = P_BLANK_ROW;
            odd_last  = P_ODD_LAST;
            even_last = P_EVEN_LAST;
        end else begin
            line_last = N_LINE_LAST;
            top_rows  = '0;
            bot_row   = N_BOT_ROW;
            blank_row = N_BLANK_ROW;
            odd_last  = N_ODD_LAST;
            even_last = N_EVEN_LAST;
        end
    end

    assign pedestal_on = ped_q & ~pal_q;
endmodule

// File: rtl/ftg_hseq.sv
module ftg_hseq
    import ftg_pkg::*;
#(
    parameter int ACT_PIX = 720,
    parameter int COL_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [COL_W-1:0] line_last,
    output logic [COL_W-1:0] col,
    output hstate_e          hstate,
    output logic             line_end
);
    localparam logic [COL_W-1:0] ACT_LAST = COL_W'(ACT_PIX - 1);

    hstate_e          h_q, h_d;
    logic [COL_W-1:0] col_q, col_d;

    assign line_end = run && (col_q == line_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q   <= H_ACTIVE;
            col_q <= '0;
        end else begin
            h_q   <= h_d;
            col_q <= col_d;
        end
    end

    always_comb begin
        h_d   = h_q;
        col_d = col_q;
        if (run) begin
            col_d = line_end ? '0 : col_q + 1'b1;
        end
        unique case (h_q)
            H_ACTIVE: if (run && col_q == ACT_LAST) h_d = H_BLANK;
            H_BLANK:  if (line_end)                 h_d = H_ACTIVE;
            default:                                h_d = H_ACTIVE;
        endcase
    end

    assign col    = col_q;
    assign hstate = h_q;
endmodule

// File: rtl/ftg_vseq.sv
module ftg_vseq
    import ftg_pkg::*;
#(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             line_end,
    input  logic [ROW_W-1:0] top_rows,
    input  logic [ROW_W-1:0] bot_row,
    input  logic [ROW_W-1:0] blank_row,
    input  logic [ROW_W-1:0] odd_last,
    input  logic [ROW_W-1:0] even_last,
    output vstate_e          vstate,
    output logic [ROW_W-1:0] row,
    output logic             field_even,
    output logic             started
);
    vstate_e          v_q, v_d;
    logic [ROW_W-1:0] row_q, row_d, row_nx, field_last;
    logic             par_q, par_d;
    vstate_e          first_st;

    assign row_nx     = row_q + 1'b1;
    // parity already flipped in blanking: 1 means the odd field is closing
    assign field_last = par_q ? odd_last : even_last;
    assign first_st   = (top_rows == '0) ? V_IMAGE : V_TOP_DARK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= V_IDLE;
            row_q <= '0;
            par_q <= 1'b0;
        end else begin
            v_q   <= v_d;
            row_q <= row_d;
            par_q <= par_d;
        end
    end

    always_comb begin
        v_d   = v_q;
        row_d = row_q;
        par_d = par_q;
        unique case (v_q)
            V_IDLE: begin
                if (pix_en) v_d = first_st;
            end
            V_TOP_DARK: begin
                if (line_end) begin
                    row_d = row_nx;
                    if (row_nx == top_rows) v_d = V_IMAGE;
                end
            end
            V_IMAGE: begin
                if (line_end) begin
                    row_d = row_nx;
                    if (row_nx == bot_row) begin
                        if (bot_row == blank_row) begin
                            v_d   = V_BLANK;
                            par_d = ~par_q;
                        end else begin
                            v_d = V_BOT_DARK;
                        end
                    end
                end
            end
            V_BOT_DARK: begin
                if (line_end) begin
                    row_d = row_nx;
                    if (row_nx == blank_row) begin
                        v_d   = V_BLANK;
                        par_d = ~par_q;
                    end
                end
            end
            V_BLANK: begin
                if (line_end) begin
                    if (row_q == field_last) begin
                        row_d = '0;
                        v_d   = first_st;
                    end else begin
                        row_d = row_nx;
                    end
                end
            end
            default: v_d = V_IDLE;
        endcase
    end

    assign vstate     = v_q;
    assign row        = row_q;
    assign field_even = par_q;
    assign started    = (v_q != V_IDLE);
endmodule

// File: rtl/field_timing_gen.sv
module field_timing_gen
    import ftg_pkg::*;
#(
    parameter int ACT_PIX         = 720,
    parameter int IMG_LINES       = 240,
    parameter int NTSC_DARK       = 3,
    parameter int PAL_DARK        = 24,
    parameter int NTSC_LINE_TOTAL = 858,
    parameter int PAL_LINE_TOTAL  = 864,
    parameter int NTSC_ODD_LINES  = 263,
    parameter int NTSC_EVEN_LINES = 262,
    parameter int PAL_ODD_LINES   = 313,
    parameter int PAL_EVEN_LINES  = 312,
    parameter int DATA_W          = 8,
    localparam int MAX_LINE       = (NTSC_LINE_TOTAL > PAL_LINE_TOTAL) ? NTSC_LINE_TOTAL : PAL_LINE_TOTAL,
    localparam int MAX_ROWS       = (NTSC_ODD_LINES > PAL_ODD_LINES) ? NTSC_ODD_LINES : PAL_ODD_LINES,
    localparam int COL_W          = $clog2(MAX_LINE),
    localparam int ROW_W          = $clog2(MAX_ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              mode_pal,
    input  logic              pedestal_req,
    input  logic [DATA_W-1:0] pix_data,
    output logic              frame_valid,
    output logic              line_valid,
    output logic              field_even,
    output logic [COL_W-1:0]  col_cnt,
    output logic [ROW_W-1:0]  row_cnt,
    output logic [1:0]        pix_sel,
    output logic [DATA_W-1:0] pix_out,
    output logic              pedestal_on
);
    logic [COL_W-1:0] line_last;
    logic [ROW_W-1:0] top_rows, bot_row, blank_row, odd_last, even_last;
    logic             started, line_end, run;
    hstate_e          hstate;
    vstate_e          vstate;
    pix_sel_e         sel;

    ftg_cfg_latch #(
        .COL_W(COL_W), .ROW_W(ROW_W), .IMG_LINES(IMG_LINES),
        .NTSC_DARK(NTSC_DARK), .PAL_DARK(PAL_DARK),
        .NTSC_LINE_TOTAL(NTSC_LINE_TOTAL), .PAL_LINE_TOTAL(PAL_LINE_TOTAL),
        .NTSC_ODD_LINES(NTSC_ODD_LINES), .NTSC_EVEN_LINES(NTSC_EVEN_LINES),
        .PAL_ODD_LINES(PAL_ODD_LINES), .PAL_EVEN_LINES(PAL_EVEN_LINES)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .mode_pal(mode_pal), .pedestal_req(pedestal_req),
        .line_last(line_last), .top_rows(top_rows), .bot_row(bot_row),
        .blank_row(blank_row), .odd_last(odd_last), .even_last(even_last),
        .pedestal_on(pedestal_on)
    );

    assign run = pix_en && started;

    ftg_hseq #(.ACT_PIX(ACT_PIX), .COL_W(COL_W)) hseq_i (
        .clk(clk), .rst_n(rst_n), .run(run), .line_last(line_last),
        .col(col_cnt), .hstate(hstate), .line_end(line_end)
    );

    ftg_vseq #(.ROW_W(ROW_W)) vseq_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_end(line_end),
        .top_rows(top_rows), .bot_row(bot_row), .blank_row(blank_row),
        .odd_last(odd_last), .even_last(even_last),
        .vstate(vstate), .row(row_cnt), .field_even(field_even), .started(started)
    );

    // output decode from the two sequencer states
    always_comb begin
        frame_valid = 1'b0;
        sel         = SEL_BLANK;
        unique case (vstate)
            V_TOP_DARK, V_BOT_DARK: begin
                frame_valid = 1'b1;
                if (hstate == H_ACTIVE) sel = SEL_DARK;
            end
            V_IMAGE: begin
                frame_valid = 1'b1;
                if (hstate == H_ACTIVE) sel = SEL_IMAGE;
            end
            default: begin
                frame_valid = 1'b0;
                sel         = SEL_BLANK;
            end
        endcase
    end

    assign line_valid = frame_valid && (hstate == H_ACTIVE);
    assign pix_sel    = sel;
    assign pix_out    = (sel == SEL_BLANK) ? '0 : pix_data;
endmodule

// File: rtl/field_timing_gen_chk.sv
module field_timing_gen_chk #(
    parameter int COL_W  = 10,
    parameter int ROW_W  = 9,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_en,
    input logic              frame_valid,
    input logic              line_valid,
    input logic              field_even,
    input logic [COL_W-1:0]  col_cnt,
    input logic [ROW_W-1:0]  row_cnt,
    input logic [1:0]        pix_sel,
    input logic [DATA_W-1:0] pix_out,
    input logic              pedestal_on
);
    AST_LV_IN_FV: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> frame_valid); // R5

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable(col_cnt) && $stable(row_cnt) && $stable(field_even))); // R2

    AST_PARITY_IN_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_even) |-> !frame_valid); // R6

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sel == 2'd0) |-> (pix_out == '0)); // R9

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sel != 2'd3); // R9

    AST_PED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(pedestal_on)); // R7
endmodule

bind field_timing_gen field_timing_gen_chk #(
    .COL_W(COL_W), .ROW_W(ROW_W), .DATA_W(DATA_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .frame_valid(frame_valid),
    .line_valid(line_valid), .field_even(field_even), .col_cnt(col_cnt),
    .row_cnt(row_cnt), .pix_sel(pix_sel), .pix_out(pix_out),
    .pedestal_on(pedestal_on)
);

// File: tb/field_timing_gen_tb_top.sv
module field_timing_gen_tb_top;
    localparam int CLK_NS = 10;
    localparam int ACT = 4;
    localparam int IMG = 4;
    localparam int ND  = 1;
    localparam int PD  = 2;
    localparam int NLT = 6;
    localparam int PLT = 7;
    localparam int NOL = 8;
    localparam int NEL = 7;
    localparam int POL = 11;
    localparam int PEL = 10;
    localparam int COL_W = 3;
    localparam int ROW_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b0;
    logic mode_pal = 1'b0;
    logic pedestal_req = 1'b0;
    logic [7:0] pix_data = 8'h00;
    logic frame_valid, line_valid, field_even, pedestal_on;
    logic [COL_W-1:0] col_cnt;
    logic [ROW_W-1:0] row_cnt;
    logic [1:0] pix_sel;
    logic [7:0] pix_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_NS/2) clk = ~clk;

    field_timing_gen #(
        .ACT_PIX(ACT), .IMG_LINES(IMG), .NTSC_DARK(ND), .PAL_DARK(PD),
        .NTSC_LINE_TOTAL(NLT), .PAL_LINE_TOTAL(PLT),
        .NTSC_ODD_LINES(NOL), .NTSC_EVEN_LINES(NEL),
        .PAL_ODD_LINES(POL), .PAL_EVEN_LINES(PEL), .DATA_W(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .mode_pal(mode_pal),
        .pedestal_req(pedestal_req), .pix_data(pix_data),
        .frame_valid(frame_valid), .line_valid(line_valid), .field_even(field_even),
        .col_cnt(col_cnt), .row_cnt(row_cnt), .pix_sel(pix_sel),
        .pix_out(pix_out), .pedestal_on(pedestal_on)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_idle(input string tag, input int exp_ped, input string ptag);
        chk(tag, "col", int'(col_cnt), 0);
        chk(tag, "row", int'(row_cnt), 0);
        chk(tag, "field_even", int'(field_even), 0);
        chk(tag, "frame_valid", int'(frame_valid), 0);
        chk(tag, "line_valid", int'(line_valid), 0);
        chk(tag, "pix_sel", int'(pix_sel), 0);
        chk(tag, "pix_out", int'(pix_out), 0);
        chk(ptag, "pedestal_on", int'(pedestal_on), exp_ped);
    endtask

    task automatic check_pos(input int n, input int pal, input int exp_ped);
        int w, lo, le, act_rows, top, m, r, c, second, par, fv, lv, sel;
        string vt;
        w        = pal ? PLT : NLT;
        lo       = pal ? POL : NOL;
        le       = pal ? PEL : NEL;
        act_rows = pal ? (2*PD + IMG) : (IMG + ND);
        top      = pal ? PD : 0;
        vt       = pal ? "R4" : "R3";
        m = n % ((lo + le) * w);
        if (m < lo * w) begin
            second = 0; r = m / w; c = m % w;
        end else begin
            second = 1; r = (m - lo*w) / w; c = (m - lo*w) % w;
        end
        par = second ^ ((r >= act_rows) ? 1 : 0);
        fv  = (r < act_rows) ? 1 : 0;
        lv  = (fv != 0 && c < ACT) ? 1 : 0;
        sel = (lv == 0) ? 0 : ((r >= top && r < top + IMG) ? 1 : 2);
        chk("R2", "col", int'(col_cnt), c);
        chk("R2", "row", int'(row_cnt), r);
        chk("R6", "field_even", int'(field_even), par);
        chk("R5", "frame_valid", int'(frame_valid), fv);
        chk("R5", "line_valid", int'(line_valid), lv);
        chk(vt, "pix_sel", int'(pix_sel), sel);
        chk("R9", "pix_out", int'(pix_out), (sel == 0) ? 0 : int'(pix_data));
        chk("R7", "pedestal_on", int'(pedestal_on), exp_ped);
    endtask

    task automatic run_cfg(input int pal, input int ped, input int gaps);
        int n, started, frames, w, lo, le, cyc, eped;
        w  = pal ? PLT : NLT;
        lo = pal ? POL : NOL;
        le = pal ? PEL : NEL;
        frames = 2;
        eped = (ped != 0 && pal == 0) ? 1 : 0;
        @(negedge clk);
        rst_n = 1'b0; pix_en = 1'b0;
        mode_pal = pal[0]; pedestal_req = ped[0];
        pix_data = 8'hA5;
        repeat (3) @(negedge clk);
        check_idle("R1", eped, "R8");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1", eped, "R8");
        n = 0; started = 0; cyc = 0;
        while (!(started != 0 && n >= frames * (lo + le) * w)) begin
            if (started != 0) check_pos(n, pal, eped);
            else check_idle("R1", eped, "R7");
            // R7: strap inputs wiggle after reset release
            mode_pal     = cyc[3];
            pedestal_req = cyc[2];
            pix_en       = (gaps != 0 && (cyc % 4) == 3) ? 1'b0 : 1'b1;
            pix_data     = 8'((n * 7 + 3) | 1);
            @(posedge clk);
            if (pix_en) begin
                if (started == 0) started = 1;
                else n++;
            end
            cyc++;
            @(negedge clk);
        end
        pix_en = 1'b0;
    endtask

    initial begin
        run_cfg(0, 1, 1);
        run_cfg(0, 0, 0);
        run_cfg(1, 1, 0);
        run_cfg(1, 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule